// File: doc/BRIEF.md
# Mailbox Send-Side Controller

This block is the transmit half of an inter-processor mailbox. A local CPU reaches it through a 32-bit register bus. Software stages a 64-bit message as two 32-bit words and names one of eight remote targets. It then writes a start command. The block places the message in that target's slot and presents it to the remote side on a per-target valid/accept handshake.

Every target has three flags: busy, delivered and overflow. Busy stays up from the moment a message is placed in the slot until the remote side takes it. Delivered records that a message entered the slot. Overflow records that a start command hit a slot that was still occupied. A delivered flag with busy low means the remote side has collected the message, which software treats as completion. Three event sources feed one latched interrupt: message delivered, overflow and remote fetch. Each source has its own mask bit.

Top module: `mbox_tx_inbox`

## Requirements
- R1: After reset the status word (offset 0x14) reads 0, the interrupt mask (0x1C) reads 3'b111, interrupt status (0x18) reads 0, `irq` is low and no `tgt_valid` bit is set.
- R2: Software writes the low word to 0x04, the high word to 0x08 and the target number to 0x00. Writing a value with bit 0 set to 0x0C then loads the message `{high, low}` into that target's slice `tgt_data[t*64 +: 64]`, raises `tgt_valid[t]`, and sets busy (status bit t) and delivered (status bit 16+t).
- R3: A start command aimed at a target whose busy bit is already set leaves that target's pending message unchanged and does not touch its delivered flag. It sets the overflow flag (status bit 8+t).
- R4: A cycle with `tgt_valid[t]` and `tgt_accept[t]` both high clears busy and `tgt_valid[t]` at the next edge. The delivered flag stays set.
- R5: A write to 0x10 clears delivered flag t wherever data bit 16+t is 1 and overflow flag t wherever data bit 8+t is 1. Other flags and all busy bits are unchanged, and the register reads 0.
- R6: Interrupt mask bit 0 disables the fetch source, bit 1 the overflow source and bit 2 the delivery source, where a 1 disables. An event whose source is masked leaves `irq` low.
- R7: Any unmasked event sets interrupt status bit 0, which drives `irq`, at the edge that ends the cycle in which the event occurs. The bit holds until software writes a value with bit 0 set to 0x18.
- R8: A write to 0x0C with bit 0 clear starts nothing. No status flag or target output changes.
- R9: The target register (low 3 bits), the low word and the high word read back what was last written.
- R10: Targets are independent. Loading, fetching or clearing one target leaves the slots and flags of the others unchanged, and several targets may be fetched in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tgt_valid | output | 8 | Per-target message pending |
| tgt_accept | input | 8 | Per-target fetch by the remote side |
| tgt_data | output | 512 | Per-target 64-bit message, target t at bits t*64 and up |
| irq | output | 1 | Latched interrupt request |

## Verification
The hardest state to reach from the ports is overflow. The bench has to keep a target occupied by holding back its accept while it issues a second full send sequence to the same target. It then confirms that the slot still carries the first message while the overflow flag rises. The bench walks all eight targets this way, first loading each one and then overflowing each one. After that it drains them singly and in a group, so it can show that neighbouring flags and slots are untouched. The mask test places each source alone behind an open mask and expects the interrupt only from that source.

// File: rtl/mbox_tx_pkg.sv
package mbox_tx_pkg;

   localparam int OFF_W = 6;

   localparam logic [OFF_W-1:0] OFF_TGT  = 6'h00;
   localparam logic [OFF_W-1:0] OFF_LO   = 6'h04;
   localparam logic [OFF_W-1:0] OFF_HI   = 6'h08;
   localparam logic [OFF_W-1:0] OFF_GO   = 6'h0C;
   localparam logic [OFF_W-1:0] OFF_CLR  = 6'h10;
   localparam logic [OFF_W-1:0] OFF_STS  = 6'h14;
   localparam logic [OFF_W-1:0] OFF_ISTS = 6'h18;
   localparam logic [OFF_W-1:0] OFF_IMSK = 6'h1C;

   // field positions inside the status word
   localparam int BUSY_LSB = 0;
   localparam int OVF_LSB  = 8;
   localparam int DLV_LSB  = 16;
   localparam int FIELD_W  = 8;

   // event vector, bit order matches the mask register
   typedef struct packed {
      logic dlv;    // bit 2
      logic ovf;    // bit 1
      logic fetch;  // bit 0
   } mbx_ev_t;

   localparam int EV_W = 3;

endpackage

// File: rtl/mbox_tx_slot.sv
module mbox_tx_slot #(
   parameter int MSG_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [MSG_W-1:0] msg_in,
   input  logic             accept,
   input  logic             clr_dlv,
   input  logic             clr_ovf,
   output logic             busy,
   output logic             dlv,
   output logic             ovf,
   output logic [MSG_W-1:0] data,
   output logic             ev_fetch,
   output logic             ev_ovf,
   output logic             ev_dlv
);

   logic             busy_q, dlv_q, ovf_q;
   logic [MSG_W-1:0] data_q;
   logic             take, reject, fetched;

   always_comb begin
      take    = load && !busy_q;
      reject  = load && busy_q;
      fetched = busy_q && accept;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         dlv_q  <= 1'b0;
         ovf_q  <= 1'b0;
         data_q <= '0;
      end else begin
         if (take)
            data_q <= msg_in;
         if (take)
            busy_q <= 1'b1;
         else if (fetched)
            busy_q <= 1'b0;
         if (take)
            dlv_q <= 1'b1;
         else if (clr_dlv)
            dlv_q <= 1'b0;
         if (reject)
            ovf_q <= 1'b1;
         else if (clr_ovf)
            ovf_q <= 1'b0;
      end
   end

   assign busy     = busy_q;
   assign dlv      = dlv_q;
   assign ovf      = ovf_q;
   assign data     = data_q;
   assign ev_fetch = fetched;
   assign ev_ovf   = reject;
   assign ev_dlv   = take;

   p_load_sets_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load && !busy |=> busy && dlv && data == $past(msg_in));

   p_keep_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load && busy && !clr_ovf |=> ovf && $stable(data));

   p_fetch_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy && accept |=> !busy);

   p_no_accept_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !accept |=> busy);

endmodule

// File: rtl/mbox_tx_regs.sv
module mbox_tx_regs
   import mbox_tx_pkg::*;
#(
   parameter int NUM_TGT = 8,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 6,
   parameter int ID_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [NUM_TGT-1:0]  busy,
   input  logic [NUM_TGT-1:0]  dlv,
   input  logic [NUM_TGT-1:0]  ovf,
   input  logic                irq_pend,
   output logic [2*DATA_W-1:0] msg,
   output logic [ID_W-1:0]     sel_id,
   output logic                go,
   output logic [NUM_TGT-1:0]  clr_dlv,
   output logic [NUM_TGT-1:0]  clr_ovf,
   output logic [EV_W-1:0]     irq_mask,
   output logic                irq_clr,
   output logic [DATA_W-1:0]   rdata
);

   localparam logic [ADDR_W-1:0] A_TGT  = ADDR_W'(OFF_TGT);
   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFF_LO);
   localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFF_HI);
   localparam logic [ADDR_W-1:0] A_GO   = ADDR_W'(OFF_GO);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
   localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFF_STS);
   localparam logic [ADDR_W-1:0] A_ISTS = ADDR_W'(OFF_ISTS);
   localparam logic [ADDR_W-1:0] A_IMSK = ADDR_W'(OFF_IMSK);

   logic [DATA_W-1:0] lo_q, hi_q;
   logic [ID_W-1:0]   id_q;
   logic [EV_W-1:0]   mask_q;
   logic              w_tgt, w_lo, w_hi, w_go, w_clr, w_ists, w_imsk;
   logic [DATA_W-1:0] sts_word;

   always_comb begin
      w_tgt  = wr_en && addr == A_TGT;
      w_lo   = wr_en && addr == A_LO;
      w_hi   = wr_en && addr == A_HI;
      w_go   = wr_en && addr == A_GO;
      w_clr  = wr_en && addr == A_CLR;
      w_ists = wr_en && addr == A_ISTS;
      w_imsk = wr_en && addr == A_IMSK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         id_q   <= '0;
         mask_q <= '1;
      end else begin
         if (w_lo)   lo_q   <= wdata;
         if (w_hi)   hi_q   <= wdata;
         if (w_tgt)  id_q   <= wdata[ID_W-1:0];
         if (w_imsk) mask_q <= wdata[EV_W-1:0];
      end
   end

   always_comb begin
      go      = w_go && wdata[0];
      irq_clr = w_ists && wdata[0];
      clr_dlv = w_clr ? wdata[DLV_LSB +: NUM_TGT] : '0;
      clr_ovf = w_clr ? wdata[OVF_LSB +: NUM_TGT] : '0;
   end

   always_comb begin
      sts_word = '0;
      sts_word[BUSY_LSB +: NUM_TGT] = busy;
      sts_word[OVF_LSB  +: NUM_TGT] = ovf;
      sts_word[DLV_LSB  +: NUM_TGT] = dlv;
   end

   always_comb begin
      case (addr)
         A_TGT:   rdata = DATA_W'(id_q);
         A_LO:    rdata = lo_q;
         A_HI:    rdata = hi_q;
         A_STS:   rdata = sts_word;
         A_ISTS:  rdata = DATA_W'(irq_pend);
         A_IMSK:  rdata = DATA_W'(mask_q);
         default: rdata = '0;
      endcase
   end

   assign msg      = {hi_q, lo_q};
   assign sel_id   = id_q;
   assign irq_mask = mask_q;

   p_id_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !w_tgt |=> $stable(sel_id));

endmodule

// File: rtl/mbox_tx_irq.sv
module mbox_tx_irq
   import mbox_tx_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  mbx_ev_t         ev,
   input  logic [EV_W-1:0] mask,
   input  logic            clr,
   output logic            irq
);

   logic [EV_W-1:0] ev_bits;
   logic            fire;
   logic            irq_q;

   always_comb begin
      ev_bits = ev;
      fire    = |(ev_bits & ~mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else if (fire)
         irq_q <= 1'b1;
      else if (clr)
         irq_q <= 1'b0;
   end

   assign irq = irq_q;

   p_irq_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !clr |=> irq);

   p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq && (ev & ~mask) == '0 |=> !irq);

endmodule

// File: rtl/mbox_tx_inbox.sv
module mbox_tx_inbox
   import mbox_tx_pkg::*;
#(
   parameter int NUM_TGT = 8,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   output logic [NUM_TGT-1:0]         tgt_valid,
   input  logic [NUM_TGT-1:0]         tgt_accept,
   output logic [NUM_TGT*2*DATA_W-1:0] tgt_data,
   output logic                       irq
);

   localparam int MSG_W = 2 * DATA_W;
   localparam int ID_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

   generate
      if (NUM_TGT < 1 || NUM_TGT > FIELD_W) begin : g_bad_tgt
         $error("NUM_TGT must lie in 1..8");
      end
      if (DATA_W != 32) begin : g_bad_w
         $error("DATA_W must be 32");
      end
      if (ADDR_W < OFF_W) begin : g_bad_a
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic [MSG_W-1:0]   msg;
   logic [ID_W-1:0]    sel_id;
   logic               go;
   logic [NUM_TGT-1:0] clr_dlv, clr_ovf;
   logic [EV_W-1:0]    irq_mask;
   logic               irq_clr;
   logic [NUM_TGT-1:0] busy, dlv, ovf;
   logic [NUM_TGT-1:0] load, fetch_v, ovf_v, dlv_v;
   mbx_ev_t            ev;

   mbox_tx_regs #(
      .NUM_TGT(NUM_TGT), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .busy(busy), .dlv(dlv), .ovf(ovf),
      .irq_pend(irq), .msg(msg), .sel_id(sel_id), .go(go),
      .clr_dlv(clr_dlv), .clr_ovf(clr_ovf), .irq_mask(irq_mask),
      .irq_clr(irq_clr), .rdata(bus_rdata)
   );

   generate
      for (genvar t = 0; t < NUM_TGT; t++) begin : g_slot
         assign load[t] = go && sel_id == ID_W'(t);

         mbox_tx_slot #(.MSG_W(MSG_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .load(load[t]), .msg_in(msg),
            .accept(tgt_accept[t]), .clr_dlv(clr_dlv[t]), .clr_ovf(clr_ovf[t]),
            .busy(busy[t]), .dlv(dlv[t]), .ovf(ovf[t]),
            .data(tgt_data[t*MSG_W +: MSG_W]),
            .ev_fetch(fetch_v[t]), .ev_ovf(ovf_v[t]), .ev_dlv(dlv_v[t])
         );
      end
   endgenerate

   always_comb begin
      ev.fetch = |fetch_v;
      ev.ovf   = |ovf_v;
      ev.dlv   = |dlv_v;
   end

   assign tgt_valid = busy;

   mbox_tx_irq u_irq (
      .clk(clk), .rst_n(rst_n), .ev(ev), .mask(irq_mask),
      .clr(irq_clr), .irq(irq)
   );

   p_idle_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(OFF_GO) && !bus_wdata[0] && tgt_accept == '0
      |=> $stable(busy) && $stable(dlv) && $stable(ovf));

   p_single_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(load) <= 1);

endmodule

// File: tb/mbox_tx_inbox_bench.sv
module mbox_tx_inbox_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [5:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NT-1:0] tgt_valid;
   logic [NT-1:0] tgt_accept = '0;
   logic [NT*64-1:0] tgt_data;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [7:0]  busy_m = '0, dlv_m = '0, ovf_m = '0;
   logic [63:0] msg_m [NT];

   always #(CLK_PERIOD/2) clk = ~clk;

   mbox_tx_inbox u_mbox_tx_inbox (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_valid(tgt_valid),
      .tgt_accept(tgt_accept), .tgt_data(tgt_data), .irq(irq)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [5:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic send(int t, logic [31:0] lo, logic [31:0] hi);
      wr(6'h04, lo);
      wr(6'h08, hi);
      wr(6'h00, 32'(t));
      wr(6'h0C, 32'h1);
      if (busy_m[t]) ovf_m[t] = 1'b1;
      else begin
         busy_m[t] = 1'b1; dlv_m[t] = 1'b1; msg_m[t] = {hi, lo};
      end
   endtask

   task automatic fetch(logic [NT-1:0] m);
      @(negedge clk);
      tgt_accept = m;
      @(negedge clk);
      tgt_accept = '0;
      busy_m = busy_m & ~m;
   endtask

   task automatic state(string req);
      logic [31:0] d;
      rd(6'h14, d);
      chk({req, " status"}, 64'(d), 64'({8'h00, dlv_m, ovf_m, busy_m}));
      chk({req, " valid"}, 64'(tgt_valid), 64'(busy_m));
      for (int t = 0; t < NT; t++)
         if (busy_m[t]) chk({req, " data"}, tgt_data[t*64 +: 64], msg_m[t]);
   endtask

   task automatic irq_clear();
      wr(6'h18, 32'h1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      for (int t = 0; t < NT; t++) msg_m[t] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      state("R1");
      rd(6'h1C, d); chk("R1 mask", 64'(d), 64'h7);
      rd(6'h18, d); chk("R1 irq status", 64'(d), 64'h0);
      chk("R1 irq pin", 64'(irq), 64'h0);

      // R9 register readback
      wr(6'h04, 32'hDEAD_BEEF); wr(6'h08, 32'h0123_4567); wr(6'h00, 32'h5);
      rd(6'h04, d); chk("R9 low word", 64'(d), 64'hDEAD_BEEF);
      rd(6'h08, d); chk("R9 high word", 64'(d), 64'h0123_4567);
      rd(6'h00, d); chk("R9 target", 64'(d), 64'h5);

      // R8 go with bit 0 clear starts nothing
      wr(6'h0C, 32'hFFFF_FFFE);
      state("R8");

      // R2 / R7 load every target with all sources unmasked
      wr(6'h1C, 32'h0);
      for (int t = 0; t < NT; t++) begin
         send(t, 32'hA000_0000 + 32'(t) * 32'h0111_0101, ~(32'h5A00_0000 + 32'(t)));
         state("R2");
         chk("R7 irq after delivery", 64'(irq), 64'h1);
         repeat (3) @(negedge clk);
         chk("R7 irq held", 64'(irq), 64'h1);
         rd(6'h18, d); chk("R7 irq status", 64'(d), 64'h1);
         irq_clear();
         chk("R7 irq cleared", 64'(irq), 64'h0);
      end

      // R3 overflow: every target is still occupied
      for (int t = 0; t < NT; t++) begin
         send(t, 32'hBAD0_0000 + 32'(t), 32'hBAD1_0000 + 32'(t));
         state("R3");
         chk("R3 irq on overflow", 64'(irq), 64'h1);
         irq_clear();
      end

      // R5 masked clear; busy untouched
      wr(6'h10, 32'h000F_F000);
      dlv_m = dlv_m & ~8'h0F; ovf_m = ovf_m & ~8'hF0;
      state("R5");
      rd(6'h10, d); chk("R5 reads zero", 64'(d), 64'h0);

      // R4 / R10 fetch single targets, then a group
      for (int t = 0; t < 4; t++) begin
         fetch(NT'(1) << t);
         state("R4 single");
      end
      fetch(8'hF0);
      state("R10 group");
      chk("R4 irq after fetch", 64'(irq), 64'h1);
      irq_clear();
      wr(6'h10, 32'h00FF_FF00);
      dlv_m = '0; ovf_m = '0;
      state("R5 full clear");

      // R6 all masked: delivery gives no interrupt
      wr(6'h1C, 32'h7);
      send(2, 32'h1111_2222, 32'h3333_4444);
      state("R6 masked send");
      chk("R6 all masked", 64'(irq), 64'h0);
      rd(6'h18, d); chk("R6 status stays 0", 64'(d), 64'h0);

      // R6 only overflow enabled
      wr(6'h1C, 32'h5);
      send(3, 32'h5555_6666, 32'h7777_8888);
      chk("R6 delivery masked", 64'(irq), 64'h0);
      send(3, 32'h9999_AAAA, 32'hBBBB_CCCC);
      state("R6 overflow");
      chk("R6 overflow unmasked", 64'(irq), 64'h1);
      irq_clear();

      // R6 only delivery enabled
      wr(6'h1C, 32'h3);
      send(2, 32'h0, 32'h0);
      chk("R6 overflow masked", 64'(irq), 64'h0);
      send(4, 32'hCAFE_0004, 32'hF00D_0004);
      chk("R6 delivery unmasked", 64'(irq), 64'h1);
      irq_clear();
      fetch(8'h04);
      chk("R6 fetch masked", 64'(irq), 64'h0);

      // R6 only fetch enabled
      wr(6'h1C, 32'h6);
      fetch(8'h08);
      state("R6 fetch");
      chk("R6 fetch unmasked", 64'(irq), 64'h1);

      // R10 neighbour slot survives other traffic
      state("R10 final");

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule